// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Block

This block holds the software-visible registers of one channel of a bus-master disk DMA engine: a command byte, a status byte and a 32-bit descriptor table pointer. Software reaches them through a simple request port that carries a byte offset, an access size and write data. Read data and the error flag come back one cycle after the request.

Changes to the run bit in the command byte become one-cycle start and abort pulses toward the DMA engine. With each start pulse the block presents the descriptor pointer value that was current when the run bit was set. The status byte keeps an active flag that software cannot write, two write-one-to-clear flags (error and interrupt), and two DMA-capable flags that software can write. The DMA engine reports the end of a transfer with a completion strobe and reports faults with an error-set strobe. The interrupt output follows the interrupt flag.

Register image: byte 0 is command (bit 0 run, bit 3 direction, the other bits read 0). Byte 2 is status (bit 0 active, bit 1 error, bit 2 interrupt, bit 5 capable-0, bit 6 capable-1, the other bits read 0). Bytes 4 to 7 hold the pointer, least significant byte first. Bytes 1 and 3 read 0. Size codes: 0 byte, 1 halfword, 2 word, 3 invalid.

Top module: `bmdma_chan_regs`

## Requirements
- R1: After reset the command byte reads 0x00, the status byte reads 0x60, the pointer reads 0, and `dma_start`, `dma_abort`, `reg_err` and `irq` are low.
- R2: A legal command write that takes the run bit (bit 0) from 0 to 1 gives a one-cycle `dma_start` pulse in the next cycle. During that pulse `dma_ptr` equals the pointer value from before the write. The active bit (status bit 0) becomes 1 in the same cycle.
- R3: A legal command write that takes the run bit from 1 to 0 gives a one-cycle `dma_abort` pulse in the next cycle and clears the active bit.
- R4: A command write that leaves the run bit unchanged gives neither a start pulse nor an abort pulse.
- R5: The direction bit (command bit 3) takes the written value only if the run bit was 0 before the write. Otherwise it keeps its previous value.
- R6: A status write has no effect on the active bit.
- R7: In a status write, a 1 in bit 1 or bit 2 clears that flag and a 0 leaves it unchanged. Bits 5 and 6 take the written value.
- R8: A pointer write stores the written word with bits 1:0 forced to 0.
- R9: A write is legal only as a byte (size 0) at offset 0 or 2, or as a word (size 2) at offset 4. Any other write, and any access with size 3, raises `reg_err` for one cycle in the next cycle and changes no register.
- R10: A completion strobe clears the run bit and the active bit and sets the interrupt bit. It takes priority over a command write in the same cycle, which then gives no pulse. `irq` equals status bit 2.
- R11: An error-set strobe sets status bit 1, and it wins over a clear of that bit written in the same cycle.
- R12: A legal read returns, in the next cycle, the register image shifted right by the offset in bytes and cut to 8, 16 or 32 bits by the size code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_req | input | 1 | Register access request, one per cycle |
| reg_wr | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 3 | Byte offset into the register image |
| reg_size | input | 2 | Access size code (0 byte, 1 half, 2 word, 3 invalid) |
| reg_wdata | input | 32 | Write data, right-aligned |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| reg_err | output | 1 | Rejected access, one-cycle pulse |
| dma_start | output | 1 | Start request pulse to the DMA engine |
| dma_abort | output | 1 | Abort request pulse to the DMA engine |
| dma_ptr | output | 32 | Descriptor pointer presented with the start pulse |
| dma_done | input | 1 | Transfer-complete strobe from the engine |
| dma_err_set | input | 1 | Error strobe from the engine |
| irq | output | 1 | Interrupt, mirrors the status interrupt bit |

## Verification
Every result of this block appears exactly one clock edge after the stimulus that causes it. That covers read data, the error pulse, the start and abort pulses with their pointer, the interrupt and the updated flags. The bench applies each request and strobe half a cycle before an edge, advances one full cycle, and compares at the next falling edge. It compares against a reference model that was advanced once for that same edge. Since the model updates exactly once per stimulus cycle, a pulse that arrives one cycle early or late, or that lasts longer than one cycle, shows up as a mismatch.

// File: rtl/bmdma_pkg.sv
// Package: shared access-size encoding, register offsets and bit positions
// for the bus-master DMA channel register block.
package bmdma_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_t;

    localparam logic [2:0] OFS_CMD  = 3'd0;
    localparam logic [2:0] OFS_STAT = 3'd2;
    localparam logic [2:0] OFS_PTR  = 3'd4;

    localparam int CMD_RUN_BIT  = 0;
    localparam int CMD_DIR_BIT  = 3;
    localparam int ST_ACT_BIT   = 0;
    localparam int ST_ERR_BIT   = 1;
    localparam int ST_IRQ_BIT   = 2;
    localparam int ST_CAP0_BIT  = 5;
    localparam int ST_CAP1_BIT  = 6;

endpackage

// File: rtl/bmdma_cmd_reg.sv
// Module: bmdma_cmd_reg
// Holds the run and direction bits of the command byte. It turns run-bit
// edges from software into start/abort events (combinational) and pulses
// (registered). Assumes at most one write per cycle. A completion strobe
// overrides the run bit and suppresses events.
module bmdma_cmd_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_run,
    input  logic wr_dir,
    input  logic done,
    output logic run_q,
    output logic dir_q,
    output logic start_evt,
    output logic stop_evt,
    output logic start_pls,
    output logic abort_pls
);

    // Edge detection against the value held before this write
    always_comb begin
        start_evt = wr_en && !done && !run_q &&  wr_run;
        stop_evt  = wr_en && !done &&  run_q && !wr_run;
    end

    // Run/direction storage and registered request pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            dir_q     <= 1'b0;
            start_pls <= 1'b0;
            abort_pls <= 1'b0;
        end else begin
            start_pls <= start_evt;
            abort_pls <= stop_evt;
            if (wr_en && !run_q)
                dir_q <= wr_dir;
            if (done)
                run_q <= 1'b0;
            else if (wr_en)
                run_q <= wr_run;
        end
    end

    AST_START_ABORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_pls && abort_pls)); // R3
    AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q)) |-> $stable(dir_q)); // R5
    AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !run_q); // R10

endmodule

// File: rtl/bmdma_stat_reg.sv
// Module: bmdma_stat_reg
// Status byte: the active flag follows start/stop/done events only, the
// error and interrupt flags are set by hardware strobes and cleared by
// writing 1, and the capable flags are plain read/write. Set wins over clear.
module bmdma_stat_reg
    import bmdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_byte,
    input  logic       start_evt,
    input  logic       stop_evt,
    input  logic       done,
    input  logic       err_set,
    output logic [7:0] stat_byte
);

    logic       act_q;
    logic       err_q;
    logic       irq_q;
    logic [1:0] cap_q;

    // Flag storage with write-one-to-clear and hardware set priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            err_q <= 1'b0;
            irq_q <= 1'b0;
            cap_q <= 2'b11;
        end else begin
            if (done || stop_evt)
                act_q <= 1'b0;
            else if (start_evt)
                act_q <= 1'b1;
            if (err_set)
                err_q <= 1'b1;
            else if (wr_en && wr_byte[ST_ERR_BIT])
                err_q <= 1'b0;
            if (done)
                irq_q <= 1'b1;
            else if (wr_en && wr_byte[ST_IRQ_BIT])
                irq_q <= 1'b0;
            if (wr_en)
                cap_q <= {wr_byte[ST_CAP1_BIT], wr_byte[ST_CAP0_BIT]};
        end
    end

    // Assemble the readable status byte
    always_comb begin
        stat_byte              = '0;
        stat_byte[ST_ACT_BIT]  = act_q;
        stat_byte[ST_ERR_BIT]  = err_q;
        stat_byte[ST_IRQ_BIT]  = irq_q;
        stat_byte[ST_CAP0_BIT] = cap_q[0];
        stat_byte[ST_CAP1_BIT] = cap_q[1];
    end

    AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> irq_q); // R10
    AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |=> err_q); // R11
    AST_ACT_NOT_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !start_evt && !stop_evt && !done) |=> $stable(act_q)); // R6

endmodule

// File: rtl/bmdma_ptr_reg.sv
// Module: bmdma_ptr_reg
// Descriptor table pointer with forced alignment, plus a launch copy that
// is captured on each start event and presented to the DMA engine.
module bmdma_ptr_reg #(
    parameter int PTR_W      = 32,
    parameter int ALIGN_BITS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_data,
    input  logic             start_evt,
    output logic [PTR_W-1:0] ptr_q,
    output logic [PTR_W-1:0] launch_q
);

    localparam logic [PTR_W-1:0] ALIGN_MASK = ~((PTR_W)'((1 << ALIGN_BITS) - 1));

    // Pointer storage and launch capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            launch_q <= '0;
        end else begin
            if (wr_en)
                ptr_q <= wr_data & ALIGN_MASK;
            if (start_evt)
                launch_q <= ptr_q;
        end
    end

    AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> (ptr_q[ALIGN_BITS-1:0] == '0)); // R8

endmodule

// File: rtl/bmdma_chan_regs.sv
// Module: bmdma_chan_regs (top)
// One channel of bus-master DMA registers. It decodes register accesses,
// checks the access size for each offset, and returns read data and the
// error flag one cycle after the request. Assumes one request per cycle.
module bmdma_chan_regs
    import bmdma_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 3,
    parameter int ALIGN_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_req,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [1:0]        reg_size,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_err,
    output logic              dma_start,
    output logic              dma_abort,
    output logic [DATA_W-1:0] dma_ptr,
    input  logic              dma_done,
    input  logic              dma_err_set,
    output logic              irq
);

    localparam int IMG_BYTES = 1 << ADDR_W;
    localparam int IMG_W     = IMG_BYTES * 8;

    acc_size_t       size;
    logic            cmd_wr, stat_wr, ptr_wr, bad_acc, rd_ok;
    logic            run_q, dir_q, start_evt, stop_evt;
    logic [7:0]      stat_byte, cmd_byte;
    logic [DATA_W-1:0] ptr_q;
    logic [IMG_W-1:0]  image, shifted;
    logic [DATA_W-1:0] rd_word;

    // Access decode and legality check
    always_comb begin
        size    = acc_size_t'(reg_size);
        cmd_wr  = reg_req && reg_wr && reg_addr == ADDR_W'(OFS_CMD)  && size == SZ_BYTE;
        stat_wr = reg_req && reg_wr && reg_addr == ADDR_W'(OFS_STAT) && size == SZ_BYTE;
        ptr_wr  = reg_req && reg_wr && reg_addr == ADDR_W'(OFS_PTR)  && size == SZ_WORD;
        rd_ok   = reg_req && !reg_wr && size != SZ_BAD;
        bad_acc = reg_req && (reg_wr ? !(cmd_wr || stat_wr || ptr_wr) : size == SZ_BAD);
    end

    bmdma_cmd_reg u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cmd_wr),
        .wr_run    (reg_wdata[CMD_RUN_BIT]),
        .wr_dir    (reg_wdata[CMD_DIR_BIT]),
        .done      (dma_done),
        .run_q     (run_q),
        .dir_q     (dir_q),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .start_pls (dma_start),
        .abort_pls (dma_abort)
    );

    bmdma_stat_reg u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (stat_wr),
        .wr_byte   (reg_wdata[7:0]),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .done      (dma_done),
        .err_set   (dma_err_set),
        .stat_byte (stat_byte)
    );

    bmdma_ptr_reg #(
        .PTR_W      (DATA_W),
        .ALIGN_BITS (ALIGN_BITS)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ptr_wr),
        .wr_data   (reg_wdata),
        .start_evt (start_evt),
        .ptr_q     (ptr_q),
        .launch_q  (dma_ptr)
    );

    // Register image, shifted to the offset and cut to the access size
    always_comb begin
        cmd_byte              = '0;
        cmd_byte[CMD_RUN_BIT] = run_q;
        cmd_byte[CMD_DIR_BIT] = dir_q;
        image                 = '0;
        image[7:0]            = cmd_byte;
        image[23:16]          = stat_byte;
        image[32 +: DATA_W]   = ptr_q;
        shifted               = image >> {reg_addr, 3'b000};
        rd_word               = shifted[DATA_W-1:0];
        case (size)
            SZ_BYTE: rd_word = rd_word & DATA_W'(8'hFF);
            SZ_HALF: rd_word = rd_word & DATA_W'(16'hFFFF);
            default: rd_word = rd_word;
        endcase
    end

    // Registered read data and error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
            reg_err   <= 1'b0;
        end else begin
            reg_err <= bad_acc;
            if (rd_ok)
                reg_rdata <= rd_word;
        end
    end

    assign irq = stat_byte[ST_IRQ_BIT];

    AST_START_SETS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |-> stat_byte[ST_ACT_BIT]); // R2
    AST_ACTIVE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        stat_byte[ST_ACT_BIT] |-> run_q); // R10
    AST_REJECT_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> $stable(ptr_q)); // R9

endmodule

// File: tb/test_bmdma_chan_regs.sv
`timescale 1ns/100ps
module test_bmdma_chan_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 1'b0, reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [1:0]  reg_size = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_err, dma_start, dma_abort, irq;
    logic [31:0] dma_ptr;
    logic        dma_done = 1'b0, dma_err_set = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model state
    bit        m_run, m_dir, m_act, m_err, m_irq;
    bit [1:0]  m_cap;
    bit [31:0] m_ptr, m_lptr;

    always #2.5 clk = ~clk;

    bmdma_chan_regs i_bmdma_chan_regs (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_err(reg_err), .dma_start(dma_start),
        .dma_abort(dma_abort), .dma_ptr(dma_ptr), .dma_done(dma_done),
        .dma_err_set(dma_err_set), .irq(irq)
    );

    function automatic bit [63:0] model_image();
        bit [7:0] c, s;
        c = {4'b0, m_dir, 2'b0, m_run};
        s = {1'b0, m_cap[1], m_cap[0], 2'b0, m_irq, m_err, m_act};
        return {m_ptr, 8'h0, s, 8'h0, c};
    endfunction

    function automatic bit [31:0] model_read(bit [2:0] a, bit [1:0] sz);
        bit [63:0] sh;
        sh = model_image() >> (a * 8);
        case (sz)
            2'd0: return {24'h0, sh[7:0]};
            2'd1: return {16'h0, sh[15:0]};
            default: return sh[31:0];
        endcase
    endfunction

    function automatic bit write_legal(bit [2:0] a, bit [1:0] sz);
        return (a == 3'd0 && sz == 2'd0) || (a == 3'd2 && sz == 2'd0) ||
               (a == 3'd4 && sz == 2'd2);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One stimulus cycle: drive at falling edge, compare at the next one
    task automatic cyc(bit req, bit wr, bit [2:0] a, bit [1:0] sz,
                       bit [31:0] d, bit dn, bit es, string tag);
        bit e_err, e_start, e_abort, cw, sw, pw, rd;
        bit [31:0] e_rd;
        e_err = req && (wr ? !write_legal(a, sz) : sz == 2'd3);
        cw = req && wr && a == 3'd0 && sz == 2'd0;
        sw = req && wr && a == 3'd2 && sz == 2'd0;
        pw = req && wr && a == 3'd4 && sz == 2'd2;
        rd = req && !wr && sz != 2'd3;
        e_rd = model_read(a, sz);
        e_start = cw && !dn && !m_run && d[0];
        e_abort = cw && !dn && m_run && !d[0];
        // next model state
        if (e_start) m_lptr = m_ptr;
        if (cw && !m_run) m_dir = d[3];
        if (dn) m_run = 0; else if (cw) m_run = d[0];
        if (dn || e_abort) m_act = 0; else if (e_start) m_act = 1;
        if (es) m_err = 1; else if (sw && d[1]) m_err = 0;
        if (dn) m_irq = 1; else if (sw && d[2]) m_irq = 0;
        if (sw) m_cap = {d[6], d[5]};
        if (pw) m_ptr = d & 32'hFFFF_FFFC;
        reg_req = req; reg_wr = wr; reg_addr = a; reg_size = sz;
        reg_wdata = d; dma_done = dn; dma_err_set = es;
        @(negedge clk);
        chk({tag, " R2 start"}, {31'b0, dma_start}, {31'b0, e_start});
        chk({tag, " R3 abort"}, {31'b0, dma_abort}, {31'b0, e_abort});
        chk({tag, " R9 err"}, {31'b0, reg_err}, {31'b0, e_err});
        chk({tag, " R10 irq"}, {31'b0, irq}, {31'b0, m_irq});
        if (e_start) chk({tag, " R2 ptr"}, dma_ptr, m_lptr);
        if (rd) chk({tag, " R12 rdata"}, reg_rdata, e_rd);
        reg_req = 0; reg_wr = 0; dma_done = 0; dma_err_set = 0;
    endtask

    task automatic rd_reg(bit [2:0] a, bit [1:0] sz, string tag);
        cyc(1, 0, a, sz, 32'h0, 0, 0, tag);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd4711);
        m_cap = 2'b11;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        chk("R1 start", {31'b0, dma_start}, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rd_reg(3'd0, 2'd0, "R1 cmd");
        rd_reg(3'd2, 2'd0, "R1 status");
        chk("R1 status value", reg_rdata, 32'h60);
        rd_reg(3'd4, 2'd2, "R1 ptr");
        // R8 pointer alignment
        cyc(1, 1, 3'd4, 2'd2, 32'h1234_5677, 0, 0, "R8");
        rd_reg(3'd4, 2'd2, "R8 read");
        chk("R8 aligned", reg_rdata, 32'h1234_5674);
        // R2 start with direction
        cyc(1, 1, 3'd0, 2'd0, 32'h09, 0, 0, "R2");
        rd_reg(3'd2, 2'd0, "R2 active");
        // R4 same run value, R5 direction held
        cyc(1, 1, 3'd0, 2'd0, 32'h01, 0, 0, "R4 R5");
        rd_reg(3'd0, 2'd0, "R5 dir held");
        chk("R5 dir value", reg_rdata, 32'h09);
        // R6 active not writable
        cyc(1, 1, 3'd2, 2'd0, 32'h60, 0, 0, "R6");
        rd_reg(3'd2, 2'd0, "R6 status");
        // R9 bad sizes and offsets
        cyc(1, 1, 3'd0, 2'd1, 32'h0, 0, 0, "R9 cmd half");
        cyc(1, 1, 3'd4, 2'd0, 32'hFF, 0, 0, "R9 ptr byte");
        cyc(1, 1, 3'd1, 2'd0, 32'hFF, 0, 0, "R9 off1");
        cyc(1, 0, 3'd0, 2'd3, 32'h0, 0, 0, "R9 rd size3");
        rd_reg(3'd0, 2'd2, "R9 unchanged");
        // R3 stop
        cyc(1, 1, 3'd0, 2'd0, 32'h00, 0, 0, "R3");
        rd_reg(3'd2, 2'd0, "R3 active");
        // R10 done coinciding with a start write
        cyc(1, 1, 3'd0, 2'd0, 32'h01, 1, 0, "R10 done+cmd");
        rd_reg(3'd0, 2'd0, "R10 cmd");
        // R7 write-one-to-clear interrupt, write zero keeps
        cyc(1, 1, 3'd2, 2'd0, 32'h00, 0, 1, "R11 set");
        cyc(1, 1, 3'd2, 2'd0, 32'h02, 0, 1, "R11 set beats clear");
        cyc(1, 1, 3'd2, 2'd0, 32'h04, 0, 0, "R7 clear irq");
        rd_reg(3'd2, 2'd0, "R7 status");
        // R2 start then R10 done
        cyc(1, 1, 3'd0, 2'd0, 32'h01, 0, 0, "R2 again");
        cyc(0, 0, 3'd0, 2'd0, 32'h0, 1, 0, "R10 done");
        rd_reg(3'd0, 2'd1, "R12 half");
        rd_reg(3'd5, 2'd2, "R12 word off5");
        // random mix
        for (int i = 0; i < 600; i++) begin
            bit [2:0] a; bit [1:0] sz; bit wr;
            if ($urandom % 2 == 0) begin
                case ($urandom % 3)
                    0: begin a = 3'd0; sz = 2'd0; end
                    1: begin a = 3'd2; sz = 2'd0; end
                    default: begin a = 3'd4; sz = 2'd2; end
                endcase
            end else begin
                a = 3'($urandom); sz = 2'($urandom);
            end
            wr = ($urandom % 2) == 1;
            cyc($urandom % 5 != 0, wr, a, sz, $urandom,
                ($urandom % 8) == 0, ($urandom % 8) == 0, "rand R12");
        end
        finish_run();
    end

    initial begin
        #100000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

endmodule